// File: doc/BRIEF.md
# Linked-List DMA Descriptor Loader

This block keeps the transfer registers of a multi-channel DMA engine and refills them from memory when a transfer finishes. Each channel owns a control word, a byte count, a source address, a destination address and a link pointer. When the data mover finishes a transfer, it pulses a fetch request with the channel number. The loader then reads a descriptor of four 32-bit words from memory, starting at the channel's link pointer. The words arrive in a fixed order: count, source, destination, then the new link pointer. Once the last word has arrived, the loader writes all four registers in one cycle.

The chain ends when the link pointer is zero or when the channel's control word selects single (unchained) mode. In that case no memory read is issued. The loader clears the channel's two activity bits in the control word. If the channel has completion interrupts enabled, it also sets that channel's bit in a shared interrupt-state register. Software clears interrupt-state bits by writing ones to them. A mask register selects which bits drive the single interrupt line.

Software reaches every register through one write port and one read port, selected by channel and register code. The memory port allows one read in flight at a time, and the response may take any number of cycles.

Top module: `dcf_fetch_top`

## Requirements
- R1: After a synchronous reset, every channel register, the interrupt-state register and the mask register are zero, and `irq`, `busy`, `fetch_done` and `mem_rd_en` are low.
- R2: A descriptor fetch issues exactly four reads, one at a time. The first read is at the channel's link pointer and each later read is at the previous address plus 4. The next read is issued in the cycle after the previous response.
- R3: A completed fetch loads count, source, destination and link (register codes 1, 2, 3, 4) from words 0, 1, 2 and 3 of the descriptor. It also gives a one-cycle `fetch_done` with `fetch_ok` high.
- R4: None of the four registers changes until the fourth word has arrived, so a partly fetched descriptor is never visible on the read port.
- R5: A fetch request on a channel whose link register is zero ends the chain. `fetch_done` pulses with `fetch_ok` low in the cycle after the request, and no memory read is issued.
- R6: If control bit 9 (unchained mode) is set, a fetch request ends the chain even when the link is non-zero, and no memory read is issued.
- R7: At chain end, if control bit 10 is set, interrupt-state bit CMPL_BASE plus the channel index is set. If control bit 10 is clear, that bit is left unchanged.
- R8: At chain end, control bits 12 and 14 of that channel are cleared and all other control bits keep their values.
- R9: `irq` is high one cycle after any interrupt-state bit and its mask bit (register code 6) are both set. Writing register code 5 clears every interrupt-state bit that is written with a 1.
- R10: A fetch request that arrives while `busy` is high is ignored.
- R11: A fetch or chain end on one channel leaves the registers of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Pulse: transfer on `fetch_ch` has finished, load its next descriptor |
| fetch_ch | input | CHW | Channel for the fetch request |
| busy | output | 1 | A descriptor fetch is in progress |
| fetch_done | output | 1 | One-cycle pulse when a request has been resolved |
| fetch_ok | output | 1 | With `fetch_done`: 1 means a descriptor was loaded, 0 means the chain ended |
| mem_rd_en | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | DW | Byte address of the read |
| mem_rd_vld | input | 1 | Read response valid |
| mem_rd_data | input | DW | Read response data |
| sw_we | input | 1 | Software register write strobe |
| sw_ch | input | CHW | Channel for the write |
| sw_sel | input | 3 | Register code: 0 control, 1 count, 2 source, 3 destination, 4 link, 5 interrupt state (write 1 to clear), 6 interrupt mask |
| sw_wdata | input | DW | Write data |
| rd_ch | input | CHW | Channel for the read port |
| rd_sel | input | 3 | Register code for the read port (same codes as `sw_sel`) |
| rd_data | output | DW | Registered read data, valid one cycle after `rd_ch`/`rd_sel` |
| irq | output | 1 | Registered OR of the interrupt-state bits that are unmasked |

## Verification
The bench holds back the fourth memory response and reads the count register in the meantime. A loader that wrote words as they arrived would expose a partial descriptor there. It sets a non-zero link together with the unchained bit, which catches a design that tests only the link for zero and issues reads. A control word with other bits set around bits 12 and 14 checks that only those two are cleared and the rest kept. A request made while a fetch is held back catches a design that accepts it and ends another channel's chain. It also checks that a channel with the enable bit clear raises no interrupt-state bit, and that clearing an interrupt-state bit drops the line.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {ST_IDLE, ST_WAIT} seq_state_t;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_COUNT = 3'd1;
  localparam logic [2:0] SEL_SRC   = 3'd2;
  localparam logic [2:0] SEL_DST   = 3'd3;
  localparam logic [2:0] SEL_LINK  = 3'd4;
  localparam logic [2:0] SEL_ISTAT = 3'd5;
  localparam logic [2:0] SEL_IMASK = 3'd6;

  localparam int CTL_SINGLE = 9;
  localparam int CTL_IEN    = 10;
  localparam int CTL_RUN_A  = 12;
  localparam int CTL_RUN_B  = 14;

  localparam int DESC_WORDS = 4;
endpackage

// File: rtl/dcf_chan_regs.sv
module dcf_chan_regs #(
  parameter int NUM_CH = 4,
  parameter int DW     = 32,
  parameter int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  sw_we,
  input  logic [CHW-1:0]                        sw_ch,
  input  logic [2:0]                            sw_sel,
  input  logic [DW-1:0]                         sw_wdata,
  input  logic                                  ld_en,
  input  logic [CHW-1:0]                        ld_ch,
  input  logic [dcf_pkg::DESC_WORDS-1:0][DW-1:0] ld_words,
  input  logic                                  end_en,
  input  logic [CHW-1:0]                        end_ch,
  input  logic [CHW-1:0]                        look_ch,
  output logic [DW-1:0]                         look_ctrl,
  output logic [DW-1:0]                         look_link,
  input  logic [CHW-1:0]                        rd_ch,
  input  logic [2:0]                            rd_sel,
  output logic [DW-1:0]                         rd_word
);
  import dcf_pkg::*;

  localparam logic [DW-1:0] RUN_CLR = ~((DW'(1) << CTL_RUN_A) | (DW'(1) << CTL_RUN_B));

  logic [DW-1:0] ctrl_q  [NUM_CH];
  logic [DW-1:0] count_q [NUM_CH];
  logic [DW-1:0] src_q   [NUM_CH];
  logic [DW-1:0] dst_q   [NUM_CH];
  logic [DW-1:0] link_q  [NUM_CH];

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CH; c++) begin
      if (rst) begin
        ctrl_q[c]  <= '0;
        count_q[c] <= '0;
        src_q[c]   <= '0;
        dst_q[c]   <= '0;
        link_q[c]  <= '0;
      end else begin
        // descriptor load has priority over a software write to the same channel
        if (ld_en && ld_ch == CHW'(c)) begin
          count_q[c] <= ld_words[0];
          src_q[c]   <= ld_words[1];
          dst_q[c]   <= ld_words[2];
          link_q[c]  <= ld_words[3];
        end else if (sw_we && sw_ch == CHW'(c)) begin
          case (sw_sel)
            SEL_COUNT: count_q[c] <= sw_wdata;
            SEL_SRC:   src_q[c]   <= sw_wdata;
            SEL_DST:   dst_q[c]   <= sw_wdata;
            SEL_LINK:  link_q[c]  <= sw_wdata;
            default: ;
          endcase
        end
        if (end_en && end_ch == CHW'(c)) begin
          ctrl_q[c] <= ctrl_q[c] & RUN_CLR;
        end else if (sw_we && sw_ch == CHW'(c) && sw_sel == SEL_CTRL) begin
          ctrl_q[c] <= sw_wdata;
        end
      end
    end
  end

  assign look_ctrl = ctrl_q[look_ch];
  assign look_link = link_q[look_ch];

  always_comb begin
    case (rd_sel)
      SEL_CTRL:  rd_word = ctrl_q[rd_ch];
      SEL_COUNT: rd_word = count_q[rd_ch];
      SEL_SRC:   rd_word = src_q[rd_ch];
      SEL_DST:   rd_word = dst_q[rd_ch];
      SEL_LINK:  rd_word = link_q[rd_ch];
      default:   rd_word = '0;
    endcase
  end
endmodule

// File: rtl/dcf_fetch_seq.sv
module dcf_fetch_seq #(
  parameter int NUM_CH = 4,
  parameter int DW     = 32,
  parameter int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  fetch_req,
  input  logic [CHW-1:0]                        fetch_ch,
  input  logic [DW-1:0]                         look_ctrl,
  input  logic [DW-1:0]                         look_link,
  output logic                                  busy,
  output logic                                  fetch_done,
  output logic                                  fetch_ok,
  output logic                                  mem_rd_en,
  output logic [DW-1:0]                         mem_rd_addr,
  input  logic                                  mem_rd_vld,
  input  logic [DW-1:0]                         mem_rd_data,
  output logic                                  ld_en,
  output logic [CHW-1:0]                        ld_ch,
  output logic [dcf_pkg::DESC_WORDS-1:0][DW-1:0] ld_words,
  output logic                                  end_en,
  output logic [CHW-1:0]                        end_ch,
  output logic                                  set_en,
  output logic [1:0]                            word_idx
);
  import dcf_pkg::*;

  localparam logic [1:0] LAST_IDX = 2'(DESC_WORDS - 1);

  seq_state_t                     state_q;
  logic [CHW-1:0]                 cur_ch_q;
  logic [1:0]                     idx_q;
  logic [DESC_WORDS-2:0][DW-1:0]  hold_q;
  logic                           chain_end;
  logic                           last_beat;

  assign chain_end = look_ctrl[CTL_SINGLE] || (look_link == '0);
  assign last_beat = (state_q == ST_WAIT) && mem_rd_vld && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cur_ch_q    <= '0;
      idx_q       <= '0;
      hold_q      <= '0;
      fetch_done  <= 1'b0;
      fetch_ok    <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
    end else begin
      fetch_done <= 1'b0;
      mem_rd_en  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (fetch_req) begin
            cur_ch_q <= fetch_ch;
            if (chain_end) begin
              fetch_done <= 1'b1;
              fetch_ok   <= 1'b0;
            end else begin
              state_q     <= ST_WAIT;
              idx_q       <= '0;
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= look_link;
            end
          end
        end
        ST_WAIT: begin
          if (mem_rd_vld) begin
            if (idx_q == LAST_IDX) begin
              state_q    <= ST_IDLE;
              fetch_done <= 1'b1;
              fetch_ok   <= 1'b1;
            end else begin
              hold_q[idx_q] <= mem_rd_data;
              idx_q         <= idx_q + 2'd1;
              mem_rd_en     <= 1'b1;
              mem_rd_addr   <= mem_rd_addr + DW'(4);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign ld_en    = last_beat;
  assign ld_ch    = cur_ch_q;
  assign ld_words = {mem_rd_data, hold_q[2], hold_q[1], hold_q[0]};
  assign end_en   = (state_q == ST_IDLE) && fetch_req && chain_end;
  assign end_ch   = fetch_ch;
  assign set_en   = end_en && look_ctrl[CTL_IEN];
  assign word_idx = idx_q;
endmodule

// File: rtl/dcf_irq.sv
module dcf_irq #(
  parameter int NUM_CH    = 4,
  parameter int DW        = 32,
  parameter int ISW       = 32,
  parameter int CMPL_BASE = 4,
  parameter int CHW       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           set_en,
  input  logic [CHW-1:0] set_ch,
  input  logic           clr_we,
  input  logic           mask_we,
  input  logic [DW-1:0]  wdata,
  output logic [ISW-1:0] istat,
  output logic [ISW-1:0] imask,
  output logic           irq
);
  logic [ISW-1:0] set_vec;
  logic [ISW-1:0] clr_vec;

  assign set_vec = set_en ? (ISW'(1) << (CMPL_BASE + int'(set_ch))) : '0;
  assign clr_vec = clr_we ? ISW'(wdata) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      istat <= '0;
      imask <= '0;
      irq   <= 1'b0;
    end else begin
      istat <= (istat & ~clr_vec) | set_vec;
      if (mask_we) imask <= ISW'(wdata);
      irq <= |(istat & imask);
    end
  end
endmodule

// File: rtl/dcf_fetch_top.sv
module dcf_fetch_top #(
  parameter int NUM_CH    = 4,
  parameter int DW        = 32,
  parameter int ISW       = 32,
  parameter int CMPL_BASE = 4,
  parameter int CHW       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fetch_req,
  input  logic [CHW-1:0] fetch_ch,
  output logic           busy,
  output logic           fetch_done,
  output logic           fetch_ok,
  output logic           mem_rd_en,
  output logic [DW-1:0]  mem_rd_addr,
  input  logic           mem_rd_vld,
  input  logic [DW-1:0]  mem_rd_data,
  input  logic           sw_we,
  input  logic [CHW-1:0] sw_ch,
  input  logic [2:0]     sw_sel,
  input  logic [DW-1:0]  sw_wdata,
  input  logic [CHW-1:0] rd_ch,
  input  logic [2:0]     rd_sel,
  output logic [DW-1:0]  rd_data,
  output logic           irq
);
  import dcf_pkg::*;

  logic [DW-1:0]                ctrl_sel, link_sel, reg_word;
  logic                         ld_en, end_en, set_en;
  logic [CHW-1:0]               ld_ch, end_ch;
  logic [DESC_WORDS-1:0][DW-1:0] ld_words;
  logic [ISW-1:0]               istat, imask;
  logic [1:0]                   word_idx;

  dcf_chan_regs #(.NUM_CH(NUM_CH), .DW(DW), .CHW(CHW)) u_regs (
    .clk(clk), .rst(rst),
    .sw_we(sw_we), .sw_ch(sw_ch), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .ld_en(ld_en), .ld_ch(ld_ch), .ld_words(ld_words),
    .end_en(end_en), .end_ch(end_ch),
    .look_ch(fetch_ch), .look_ctrl(ctrl_sel), .look_link(link_sel),
    .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_word(reg_word)
  );

  dcf_fetch_seq #(.NUM_CH(NUM_CH), .DW(DW), .CHW(CHW)) u_seq (
    .clk(clk), .rst(rst),
    .fetch_req(fetch_req), .fetch_ch(fetch_ch),
    .look_ctrl(ctrl_sel), .look_link(link_sel),
    .busy(busy), .fetch_done(fetch_done), .fetch_ok(fetch_ok),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_vld(mem_rd_vld), .mem_rd_data(mem_rd_data),
    .ld_en(ld_en), .ld_ch(ld_ch), .ld_words(ld_words),
    .end_en(end_en), .end_ch(end_ch), .set_en(set_en),
    .word_idx(word_idx)
  );

  dcf_irq #(.NUM_CH(NUM_CH), .DW(DW), .ISW(ISW), .CMPL_BASE(CMPL_BASE), .CHW(CHW)) u_irq (
    .clk(clk), .rst(rst),
    .set_en(set_en), .set_ch(end_ch),
    .clr_we(sw_we && sw_sel == SEL_ISTAT),
    .mask_we(sw_we && sw_sel == SEL_IMASK),
    .wdata(sw_wdata),
    .istat(istat), .imask(imask), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_sel)
        SEL_ISTAT: rd_data <= DW'(istat);
        SEL_IMASK: rd_data <= DW'(imask);
        default:   rd_data <= reg_word;
      endcase
    end
  end
endmodule

// File: rtl/dcf_fetch_checker.sv
module dcf_fetch_checker #(
  parameter int DW  = 32,
  parameter int ISW = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input logic           fetch_done,
  input logic           fetch_ok,
  input logic           mem_rd_en,
  input logic [DW-1:0]  mem_rd_addr,
  input logic           mem_rd_vld,
  input logic [1:0]     word_idx,
  input logic [ISW-1:0] istat,
  input logic [ISW-1:0] imask,
  input logic           irq
);
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && mem_rd_vld && word_idx != 2'd3) |=> (mem_rd_en && mem_rd_addr == $past(mem_rd_addr) + DW'(4)));

  assert_one_read_R2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    fetch_done |=> !fetch_done);

  assert_ok_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (fetch_done && fetch_ok) |-> !busy);

  assert_end_noread_R5: assert property (@(posedge clk) disable iff (rst)
    (fetch_done && !fetch_ok) |-> (!mem_rd_en && !busy));

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !(|(istat & imask)) |=> !irq);

  assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd_en, fetch_done}));
endmodule

bind dcf_fetch_top dcf_fetch_checker #(.DW(DW), .ISW(ISW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .fetch_done(fetch_done), .fetch_ok(fetch_ok),
  .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_vld(mem_rd_vld),
  .word_idx(word_idx), .istat(istat), .imask(imask), .irq(irq)
);

// File: tb/dcf_fetch_top_test.sv
`timescale 1ns/1ps
module dcf_fetch_top_test;
  localparam int DW = 32;
  localparam int CHW = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           fetch_req = 1'b0;
  logic [CHW-1:0] fetch_ch = '0;
  logic           busy, fetch_done, fetch_ok, mem_rd_en, irq;
  logic [DW-1:0]  mem_rd_addr, rd_data;
  logic           mem_rd_vld = 1'b0;
  logic [DW-1:0]  mem_rd_data = '0;
  logic           sw_we = 1'b0;
  logic [CHW-1:0] sw_ch = '0;
  logic [2:0]     sw_sel = '0;
  logic [DW-1:0]  sw_wdata = '0;
  logic [CHW-1:0] rd_ch = '0;
  logic [2:0]     rd_sel = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dcf_fetch_top uut (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_ch(fetch_ch),
    .busy(busy), .fetch_done(fetch_done), .fetch_ok(fetch_ok),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_vld(mem_rd_vld), .mem_rd_data(mem_rd_data),
    .sw_we(sw_we), .sw_ch(sw_ch), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  // memory model: one response one cycle after the request, can be held back
  logic [DW-1:0] mem [0:63];
  logic          pend = 1'b0;
  logic [DW-1:0] paddr = '0;
  int            resp_cnt = 0;
  int            hold_at = 1000;
  int            n_reads = 0;
  logic [DW-1:0] rd_log [0:7];

  always @(posedge clk) begin
    mem_rd_vld <= 1'b0;
    if (mem_rd_en) begin
      pend  <= 1'b1;
      paddr <= mem_rd_addr;
      if (n_reads < 8) rd_log[n_reads] <= mem_rd_addr;
      n_reads <= n_reads + 1;
    end else if (pend && resp_cnt != hold_at) begin
      mem_rd_vld  <= 1'b1;
      mem_rd_data <= mem[paddr[7:2]];
      pend        <= 1'b0;
      resp_cnt    <= resp_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sw_write(input int ch, input logic [2:0] sel, input logic [DW-1:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_ch = CHW'(ch); sw_sel = sel; sw_wdata = d;
    @(posedge clk); #1;
    sw_we = 1'b0;
  endtask

  task automatic reg_read(input int ch, input logic [2:0] sel, output logic [DW-1:0] d);
    @(negedge clk);
    rd_ch = CHW'(ch); rd_sel = sel;
    @(posedge clk); #1;
    d = rd_data;
  endtask

  task automatic pulse_fetch(input int ch);
    @(negedge clk);
    fetch_req = 1'b1; fetch_ch = CHW'(ch);
    @(posedge clk); #1;
    fetch_req = 1'b0;
  endtask

  task automatic wait_done(output logic ok);
    int n = 0;
    while (!fetch_done && n < 40) begin
      @(posedge clk); #1;
      n++;
    end
    check("R3 done seen", {31'b0, fetch_done}, 32'd1);
    ok = fetch_ok;
  endtask

  task automatic setup_desc(input int base, input logic [DW-1:0] c, input logic [DW-1:0] s,
                            input logic [DW-1:0] d, input logic [DW-1:0] l);
    mem[base/4] = c; mem[base/4+1] = s; mem[base/4+2] = d; mem[base/4+3] = l;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    check("R1 busy", {31'b0, busy}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 rd_en", {31'b0, mem_rd_en}, 0);
    reg_read(0, 3'd0, v); check("R1 ctrl", v, 0);
    reg_read(3, 3'd4, v); check("R1 link", v, 0);
    reg_read(0, 3'd5, v); check("R1 istat", v, 0);
  endtask

  task automatic t_load();
    logic ok; logic [DW-1:0] v; int r0;
    setup_desc(32'h40, 32'h0000_0100, 32'h1000_0000, 32'h2000_0000, 32'h80);
    setup_desc(32'h80, 32'h0000_0200, 32'h1100_0000, 32'h2200_0000, 32'h0);
    sw_write(0, 3'd4, 32'h40);
    sw_write(1, 3'd1, 32'h0000_0777);
    r0 = n_reads;
    pulse_fetch(0);
    wait_done(ok);
    check("R3 ok", {31'b0, ok}, 1);
    check("R2 read count", n_reads - r0, 4);
    check("R2 addr0", rd_log[r0], 32'h40);
    check("R2 addr1", rd_log[r0+1], 32'h44);
    check("R2 addr2", rd_log[r0+2], 32'h48);
    check("R2 addr3", rd_log[r0+3], 32'h4C);
    reg_read(0, 3'd1, v); check("R3 count", v, 32'h0000_0100);
    reg_read(0, 3'd2, v); check("R3 src", v, 32'h1000_0000);
    reg_read(0, 3'd3, v); check("R3 dst", v, 32'h2000_0000);
    reg_read(0, 3'd4, v); check("R3 link", v, 32'h80);
    reg_read(1, 3'd1, v); check("R11 other count", v, 32'h0000_0777);
    reg_read(1, 3'd4, v); check("R11 other link", v, 0);
    pulse_fetch(0);
    wait_done(ok);
    check("R3 second ok", {31'b0, ok}, 1);
    reg_read(0, 3'd1, v); check("R3 second count", v, 32'h0000_0200);
    reg_read(0, 3'd4, v); check("R3 second link", v, 0);
  endtask

  task automatic t_end_zero();
    logic ok; logic [DW-1:0] v; int r0;
    sw_write(0, 3'd0, 32'h0000_F403);
    r0 = n_reads;
    pulse_fetch(0);
    check("R5 done next cycle", {31'b0, fetch_done}, 1);
    check("R5 ok low", {31'b0, fetch_ok}, 0);
    repeat (3) @(posedge clk); #1;
    check("R5 no reads", n_reads - r0, 0);
    reg_read(0, 3'd0, v); check("R8 ctrl cleared", v, 32'h0000_A403);
    reg_read(0, 3'd5, v); check("R7 istat bit4", v, 32'h0000_0010);
    check("R9 masked irq low", {31'b0, irq}, 0);
    sw_write(0, 3'd6, 32'h0000_0010);
    @(posedge clk); #1;
    check("R9 irq high", {31'b0, irq}, 1);
    sw_write(0, 3'd5, 32'h0000_0010);
    @(posedge clk); #1;
    check("R9 irq after clear", {31'b0, irq}, 0);
    reg_read(0, 3'd5, v); check("R9 istat cleared", v, 0);
  endtask

  task automatic t_single();
    logic ok; logic [DW-1:0] v; int r0;
    sw_write(2, 3'd4, 32'h40);
    sw_write(2, 3'd0, 32'h0000_1200);
    r0 = n_reads;
    pulse_fetch(2);
    wait_done(ok);
    check("R6 ok low", {31'b0, ok}, 0);
    repeat (3) @(posedge clk); #1;
    check("R6 no reads", n_reads - r0, 0);
    reg_read(2, 3'd0, v); check("R8 single ctrl", v, 32'h0000_0200);
    reg_read(2, 3'd5, v); check("R7 no bit without enable", v, 0);
    reg_read(2, 3'd4, v); check("R6 link kept", v, 32'h40);
  endtask

  task automatic t_partial_busy();
    logic ok; logic [DW-1:0] v;
    sw_write(1, 3'd0, 32'h0000_1400);
    sw_write(3, 3'd4, 32'h40);
    hold_at = resp_cnt + 3;
    pulse_fetch(3);
    repeat (12) @(posedge clk); #1;
    check("R4 still busy", {31'b0, busy}, 1);
    reg_read(3, 3'd1, v); check("R4 count not yet", v, 0);
    reg_read(3, 3'd4, v); check("R4 link not yet", v, 32'h40);
    pulse_fetch(1);
    repeat (2) @(posedge clk); #1;
    hold_at = 1000;
    wait_done(ok);
    check("R4 ok", {31'b0, ok}, 1);
    reg_read(3, 3'd1, v); check("R4 count loaded", v, 32'h0000_0100);
    reg_read(3, 3'd4, v); check("R4 link loaded", v, 32'h80);
    reg_read(1, 3'd0, v); check("R10 ctrl untouched", v, 32'h0000_1400);
    reg_read(1, 3'd5, v); check("R10 no istat", v, 0);
    check("R10 no extra done", {31'b0, fetch_done}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 + i;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_load();
    t_end_zero();
    t_single();
    t_partial_busy();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule